// File: doc/BRIEF.md
# NAND Command Controller with Read-Retry and Wear Cycling

This block sits between a host request port and an abstracted command bus of a two-bit-per-cell NAND flash device. It accepts one request at a time over a valid/ready handshake, issues the matching flash command, waits on the device's ready/busy line and returns a single response carrying a pass/fail flag and a data word. The six ordinary operations are device reset, identifier read, status read, block erase, page program and page read.

Read-retry support comes from a table of three read-threshold indices, each eight bits wide. The table drives the flash side continuously, so every later page read senses with the adjusted levels. The host can overwrite any single entry and can read any entry back.

A wear mode runs a self-contained loop for a host-chosen number of passes. Each pass erases the block, programs a test pattern into it, reads the page back and counts the bits that differ. The largest count seen across all passes is the result. Software uses this mode to age a block and to watch its raw error rate grow.

Top module: `nand_rr_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` and `fl_cmd` are 0. `fl_ref_lvl` holds 64, 128 and 192 in reference slots 0, 1 and 2. Slot k occupies bits [8k+7:8k].
- R2: Op codes 0 (reset), 1 (identifier), 2 (status), 3 (erase), 4 (program) and 5 (read) each give exactly one single-cycle `fl_cmd` pulse, in the cycle after acceptance. With that pulse, `fl_op` equals the op code, `fl_addr` equals `req_addr` and `fl_wdata` equals `req_wdata`.
- R3: From acceptance of a flash operation until its response, `req_ready` stays 0. `fl_rb` (1 = ready) is ignored during the two cycles that follow the `fl_cmd` pulse. The response appears one cycle after the first clock edge that samples `fl_rb` high, so a device busy for b cycles gives a response b+2 cycles after `fl_cmd`.
- R4: Identifier, status and read operations return `fl_rdata` on `rsp_data` with `rsp_fail` 0. Erase and program operations return `rsp_data` 0 and `rsp_fail` equal to `fl_fail`. Reset returns 0 with `rsp_fail` 0.
- R5: Op 6 with `req_ref_sel` between 0 and 2 writes `req_wdata[7:0]` into that slot. The new value is visible on `fl_ref_lvl` in the cycle after acceptance, `rsp_valid` rises in that same cycle with `rsp_fail` 0, and no flash command is issued.
- R6: Op 7 returns the selected slot, zero-extended, one cycle after acceptance. This holds even when it is accepted directly after a write to that slot.
- R7: Ops 6 and 7 with `req_ref_sel` 3 respond with `rsp_fail` 1 and data 0, and leave `fl_ref_lvl` unchanged.
- R8: Op codes 9 to 15 respond one cycle after acceptance with `rsp_fail` 1 and issue no flash command.
- R9: Op 8 with a nonzero `req_iters` N issues the sequence erase (3), program (4), read (5) N times, in that order. Every command uses the same `req_addr`, and `fl_wdata` equals `req_wdata`.
- R10: Each wear pass counts the set bits of read word XOR pattern. A completed run responds with `rsp_fail` 0 and `rsp_data` equal to the maximum count over all passes.
- R11: An erase or program that ends with `fl_fail` 1 during a wear run stops the run at once. The response has `rsp_fail` 1 and carries the maximum count of the passes completed before the failure, and no further command follows.
- R12: Op 8 with `req_iters` 0 responds one cycle after acceptance with data 0 and `rsp_fail` 0, and issues no flash command.
- R13: A request held valid while an operation is in progress is accepted in the cycle that operation's response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 4 | Operation code |
| req_addr | input | 12 | Block/page address |
| req_wdata | input | 16 | Program word, wear pattern, or threshold value in bits 7:0 |
| req_ref_sel | input | 2 | Threshold slot for ops 6 and 7 |
| req_iters | input | 8 | Wear pass count |
| rsp_valid | output | 1 | Response strobe |
| rsp_fail | output | 1 | Response failure flag |
| rsp_data | output | 16 | Response data |
| fl_cmd | output | 1 | Flash command strobe |
| fl_op | output | 3 | Flash command code |
| fl_addr | output | 12 | Flash address |
| fl_wdata | output | 16 | Flash program data |
| fl_ref_lvl | output | 24 | Three threshold indices, slot 0 in the low byte |
| fl_rb | input | 1 | Device ready (1) or busy (0) |
| fl_fail | input | 1 | Device status failure for erase/program |
| fl_rdata | input | 16 | Device read data |

## Verification
Two events can land in one cycle. The response of one operation can be presented in the same cycle that the next request is accepted, because the ready line rises at the moment a result is produced. The bench provokes this by queuing a second request behind a running flash operation, and behind a threshold write followed at once by a read-back. It judges the overlap by seeing `rsp_valid` and `req_ready` high together, and by checking that the read-back returns the freshly written index. The flash command stream is scored in order against the expected sequence, so an extra or missing command in a wear run or an aborted run is reported.

// File: rtl/nand_rr_pkg.sv
package nand_rr_pkg;

  typedef enum logic [3:0] {
    OP_RESET  = 4'd0,
    OP_RDID   = 4'd1,
    OP_RDSTAT = 4'd2,
    OP_ERASE  = 4'd3,
    OP_PROG   = 4'd4,
    OP_READ   = 4'd5,
    OP_SETREF = 4'd6,
    OP_GETREF = 4'd7,
    OP_WEAR   = 4'd8
  } host_op_e;

  typedef enum logic [2:0] {
    FL_RESET  = 3'd0,
    FL_RDID   = 3'd1,
    FL_RDSTAT = 3'd2,
    FL_ERASE  = 3'd3,
    FL_PROG   = 3'd4,
    FL_READ   = 3'd5
  } fl_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_SETTLE,
    ST_WAIT,
    ST_CMP
  } ctl_state_e;

  // host codes that map one-to-one onto a device command
  function automatic logic is_flash_op(input logic [3:0] op);
    return op <= 4'd5;
  endfunction

  // device commands whose completion carries a word back
  function automatic logic returns_data(input fl_op_e f);
    return (f == FL_RDID) || (f == FL_RDSTAT) || (f == FL_READ);
  endfunction

  // device commands whose completion carries a pass/fail status
  function automatic logic reports_status(input fl_op_e f);
    return (f == FL_ERASE) || (f == FL_PROG);
  endfunction

  // population count used for the wear compare
  function automatic logic [6:0] ones64(input logic [63:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) n = n + 7'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/nand_ref_table.sv
module nand_ref_table #(
  parameter int REF_W = 8,
  parameter int NREF  = 3,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      sel,
  input  logic [REF_W-1:0]      wr_val,
  output logic [REF_W-1:0]      rd_val,
  output logic                  sel_ok,
  output logic [NREF*REF_W-1:0] lvl
);

  assign sel_ok = 32'(sel) < 32'(NREF);

  for (genvar gi = 0; gi < NREF; gi++) begin : g_slot
    localparam logic [REF_W-1:0] DEF = REF_W'((gi + 1) << (REF_W - 2));
    logic [REF_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                val_q <= DEF;
      else if (wr_en && (sel == SEL_W'(gi)))     val_q <= wr_val;
    end
    assign lvl[gi*REF_W +: REF_W] = val_q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREF; i++)
      if (sel == SEL_W'(i)) rd_val = lvl[i*REF_W +: REF_W];
  end

endmodule

// File: rtl/nand_wear_track.sv
module nand_wear_track
  import nand_rr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ITER_W = 8,
  parameter int ERR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ITER_W-1:0] iters,
  input  logic              cmp_fire,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] pattern,
  output logic [ERR_W-1:0]  max_q,
  output logic [ERR_W-1:0]  max_next,
  output logic              last_iter
);

  logic [ITER_W-1:0] remain_q;
  logic [ERR_W-1:0]  err_cnt;

  assign err_cnt   = ERR_W'(ones64(64'(rd_word ^ pattern)));
  assign max_next  = (err_cnt > max_q) ? err_cnt : max_q;
  assign last_iter = (remain_q == ITER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      max_q    <= '0;
    end else if (start) begin
      remain_q <= iters;
      max_q    <= '0;
    end else if (cmp_fire) begin
      remain_q <= remain_q - ITER_W'(1);
      max_q    <= max_next;
    end
  end

endmodule

// File: rtl/nand_rr_ctrl.sv
module nand_rr_ctrl
  import nand_rr_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int ADDR_W = 12,
  parameter  int ITER_W = 8,
  parameter  int REF_W  = 8,
  parameter  int NREF   = 3,
  localparam int SEL_W  = $clog2(NREF + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [3:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [SEL_W-1:0]      req_ref_sel,
  input  logic [ITER_W-1:0]     req_iters,
  output logic                  rsp_valid,
  output logic                  rsp_fail,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  fl_cmd,
  output logic [2:0]            fl_op,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [DATA_W-1:0]     fl_wdata,
  output logic [NREF*REF_W-1:0] fl_ref_lvl,
  input  logic                  fl_rb,
  input  logic                  fl_fail,
  input  logic [DATA_W-1:0]     fl_rdata
);

  localparam int ERR_W = $clog2(DATA_W + 1);

  ctl_state_e        state;
  fl_op_e            fop_q;
  logic              wear_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;

  // named internal events
  logic accept;
  logic wr_ref;
  logic wear_start;
  logic cmp_fire;
  logic sel_ok;
  logic [REF_W-1:0] ref_rd;
  logic [ERR_W-1:0] max_q;
  logic [ERR_W-1:0] max_next;
  logic             last_iter;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign wr_ref     = accept && (req_op == OP_SETREF) && sel_ok;
  assign wear_start = accept && (req_op == OP_WEAR);
  assign cmp_fire   = (state == ST_CMP);

  assign fl_cmd   = (state == ST_ISSUE);
  assign fl_op    = fop_q;
  assign fl_addr  = addr_q;
  assign fl_wdata = wdata_q;

  nand_ref_table #(.REF_W(REF_W), .NREF(NREF), .SEL_W(SEL_W)) u_refs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ref),
    .sel    (req_ref_sel),
    .wr_val (req_wdata[REF_W-1:0]),
    .rd_val (ref_rd),
    .sel_ok (sel_ok),
    .lvl    (fl_ref_lvl)
  );

  nand_wear_track #(.DATA_W(DATA_W), .ITER_W(ITER_W), .ERR_W(ERR_W)) u_wear (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (wear_start),
    .iters     (req_iters),
    .cmp_fire  (cmp_fire),
    .rd_word   (rd_q),
    .pattern   (wdata_q),
    .max_q     (max_q),
    .max_next  (max_next),
    .last_iter (last_iter)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fop_q     <= FL_RESET;
      wear_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            if (is_flash_op(req_op)) begin
              fop_q  <= fl_op_e'(req_op[2:0]);
              wear_q <= 1'b0;
              state  <= ST_ISSUE;
            end else if (req_op == OP_SETREF) begin
              rsp_valid <= 1'b1;
              rsp_fail  <= !sel_ok;
              rsp_data  <= '0;
            end else if (req_op == OP_GETREF) begin
              rsp_valid <= 1'b1;
              rsp_fail  <= !sel_ok;
              rsp_data  <= sel_ok ? DATA_W'(ref_rd) : '0;
            end else if (req_op == OP_WEAR) begin
              if (req_iters == '0) begin
                rsp_valid <= 1'b1;
                rsp_fail  <= 1'b0;
                rsp_data  <= '0;
              end else begin
                wear_q <= 1'b1;
                fop_q  <= FL_ERASE;
                state  <= ST_ISSUE;
              end
            end else begin
              rsp_valid <= 1'b1;
              rsp_fail  <= 1'b1;
              rsp_data  <= '0;
            end
          end
        end
        ST_ISSUE:  state <= ST_SETTLE;
        ST_SETTLE: state <= ST_WAIT;
        ST_WAIT: begin
          if (fl_rb) begin
            if (!wear_q) begin
              rsp_valid <= 1'b1;
              rsp_fail  <= reports_status(fop_q) && fl_fail;
              rsp_data  <= returns_data(fop_q) ? fl_rdata : '0;
              state     <= ST_IDLE;
            end else if (fop_q == FL_READ) begin
              rd_q  <= fl_rdata;
              state <= ST_CMP;
            end else if (fl_fail) begin
              rsp_valid <= 1'b1;
              rsp_fail  <= 1'b1;
              rsp_data  <= DATA_W'(max_q);
              state     <= ST_IDLE;
            end else begin
              fop_q <= (fop_q == FL_ERASE) ? FL_PROG : FL_READ;
              state <= ST_ISSUE;
            end
          end
        end
        ST_CMP: begin
          if (last_iter) begin
            rsp_valid <= 1'b1;
            rsp_fail  <= 1'b0;
            rsp_data  <= DATA_W'(max_next);
            state     <= ST_IDLE;
          end else begin
            fop_q <= FL_ERASE;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_rr_ctrl_chk.sv
module nand_rr_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int ITER_W = 8,
  parameter int REF_W  = 8,
  parameter int NREF   = 3,
  parameter int SEL_W  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [3:0]            req_op,
  input logic [SEL_W-1:0]      req_ref_sel,
  input logic [DATA_W-1:0]     req_wdata,
  input logic [ITER_W-1:0]     req_iters,
  input logic                  rsp_valid,
  input logic                  rsp_fail,
  input logic [DATA_W-1:0]     rsp_data,
  input logic                  fl_cmd,
  input logic [2:0]            fl_op,
  input logic [NREF*REF_W-1:0] fl_ref_lvl,
  input logic                  accept,
  input logic                  wr_ref,
  input logic                  cmp_fire
);

  logic [SEL_W-1:0] sel_d;
  logic [REF_W-1:0] val_d;
  logic             hs_seen;

  always_ff @(posedge clk) begin
    sel_d   <= req_ref_sel;
    val_d   <= req_wdata[REF_W-1:0];
    hs_seen <= req_valid && req_ready;
  end

  function automatic logic [REF_W-1:0] slot_of(input logic [NREF*REF_W-1:0] v,
                                               input logic [SEL_W-1:0] s);
    logic [REF_W-1:0] r;
    r = '0;
    for (int i = 0; i < NREF; i++)
      if (s == SEL_W'(i)) r = v[i*REF_W +: REF_W];
    return r;
  endfunction

  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd |-> !req_ready);

  p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd |=> !fl_cmd);

  p_cmd_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op < 4'd6) |=> (fl_cmd && fl_op == $past(req_op[2:0])));

  p_wear_erase_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 4'd8 && req_iters != '0) |=> (fl_cmd && fl_op == 3'd3));

  p_ref_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ref |=> (slot_of(fl_ref_lvl, sel_d) == val_d && rsp_valid && !rsp_fail));

  p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ref |=> $stable(fl_ref_lvl));

  p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op > 4'd8) |=> (rsp_valid && rsp_fail && !fl_cmd));

  p_zero_wear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 4'd8 && req_iters == '0) |=> (rsp_valid && !rsp_fail && rsp_data == '0));

  p_cmp_internal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |-> (!fl_cmd && !req_ready && !hs_seen));

endmodule

bind nand_rr_ctrl nand_rr_ctrl_chk #(
  .DATA_W(DATA_W), .ITER_W(ITER_W), .REF_W(REF_W), .NREF(NREF), .SEL_W(SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_ref_sel (req_ref_sel),
  .req_wdata   (req_wdata),
  .req_iters   (req_iters),
  .rsp_valid   (rsp_valid),
  .rsp_fail    (rsp_fail),
  .rsp_data    (rsp_data),
  .fl_cmd      (fl_cmd),
  .fl_op       (fl_op),
  .fl_ref_lvl  (fl_ref_lvl),
  .accept      (accept),
  .wr_ref      (wr_ref),
  .cmp_fire    (cmp_fire)
);

// File: tb/nand_rr_ctrl_test.sv
module nand_rr_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_ref_sel = '0;
  logic [7:0]  req_iters = '0;
  logic        rsp_valid, rsp_fail;
  logic [15:0] rsp_data;
  logic        fl_cmd;
  logic [2:0]  fl_op;
  logic [11:0] fl_addr;
  logic [15:0] fl_wdata;
  logic [23:0] fl_ref_lvl;
  logic        fl_rb;
  logic        fl_fail;
  logic [15:0] fl_rdata;

  always #10 clk = ~clk;

  nand_rr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ref_sel(req_ref_sel), .req_iters(req_iters), .rsp_valid(rsp_valid),
    .rsp_fail(rsp_fail), .rsp_data(rsp_data), .fl_cmd(fl_cmd), .fl_op(fl_op),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ref_lvl(fl_ref_lvl),
    .fl_rb(fl_rb), .fl_fail(fl_fail), .fl_rdata(fl_rdata)
  );

  typedef struct { logic fail; logic [15:0] data; string tag; } rsp_t;
  typedef struct { logic [2:0] op; logic [11:0] addr; logic [15:0] wd; string tag; } cmd_t;

  rsp_t exp_q[$];
  cmd_t cmd_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cmd_cyc = 0;
  int rsp_cyc = 0;
  bit overlap_seen = 1'b0;
  bit done = 1'b0;

  // flash device model
  int          busy_cycles = 3;
  int          busy_left = 0;
  int          ep_count = 0;
  int          fail_idx = -1;
  logic [2:0]  pend_op = '0;
  logic        pend_fail = 1'b0;
  logic [15:0] page_word = 16'h0000;
  logic [15:0] rd_words[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      fl_rb     <= 1'b1;
      fl_fail   <= 1'b0;
      fl_rdata  <= '0;
      busy_left <= 0;
    end else if (fl_cmd) begin
      fl_rb     <= 1'b0;
      busy_left <= busy_cycles;
      pend_op   <= fl_op;
      pend_fail <= 1'b0;
      if (fl_op == 3'd3 || fl_op == 3'd4) begin
        pend_fail <= (ep_count == fail_idx);
        ep_count  <= ep_count + 1;
      end
    end else if (busy_left != 0) begin
      busy_left <= busy_left - 1;
      if (busy_left == 1) begin
        fl_rb   <= 1'b1;
        fl_fail <= pend_fail;
        case (pend_op)
          3'd1: fl_rdata <= 16'hA5C3;
          3'd2: fl_rdata <= 16'h00E0;
          3'd5: fl_rdata <= (rd_words.size() != 0) ? rd_words.pop_front() : page_word;
          default: fl_rdata <= 16'h0000;
        endcase
      end
    end
  end

  // scoreboard monitor
  rsp_t mr;
  cmd_t mc;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (fl_cmd) begin
        chk(!req_ready, "R3 ready low while command runs", 32'(req_ready), 0);
        if (cmd_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected flash command actual %0d expected none", fl_op);
        end else begin
          mc = cmd_q.pop_front();
          chk(fl_op == mc.op && fl_addr == mc.addr && fl_wdata == mc.wd, mc.tag,
              {1'b0, fl_op, fl_addr, fl_wdata}, {1'b0, mc.op, mc.addr, mc.wd});
        end
        cmd_cyc = cyc;
      end
      if (rsp_valid) begin
        if (req_ready && req_valid) overlap_seen = 1'b1;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected response actual %0h expected none", rsp_data);
        end else begin
          mr = exp_q.pop_front();
          chk(rsp_fail == mr.fail && rsp_data == mr.data, mr.tag,
              {15'd0, rsp_fail, rsp_data}, {15'd0, mr.fail, mr.data});
        end
        rsp_cyc = cyc;
      end
    end
  end

  task automatic push_rsp(input logic f, input logic [15:0] d, input string t);
    rsp_t r;
    r.fail = f; r.data = d; r.tag = t;
    exp_q.push_back(r);
  endtask

  task automatic push_cmd(input logic [2:0] op, input logic [11:0] a, input logic [15:0] w, input string t);
    cmd_t c;
    c.op = op; c.addr = a; c.wd = w; c.tag = t;
    cmd_q.push_back(c);
  endtask

  // driver: called at a negedge, returns at a negedge after acceptance
  task automatic send(input logic [3:0] op, input logic [11:0] a, input logic [15:0] w,
                      input logic [1:0] sel, input logic [7:0] n);
    req_op = op; req_addr = a; req_wdata = w; req_ref_sel = sel; req_iters = n;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !fl_cmd, "R1 outputs in reset",
        {29'd0, req_ready, rsp_valid, fl_cmd}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fl_cmd, "R1 outputs after reset",
        {29'd0, req_ready, rsp_valid, fl_cmd}, 32'h4);
    chk(fl_ref_lvl == 24'hC08040, "R1 default thresholds", 32'(fl_ref_lvl), 32'hC08040);

    // ordinary operations (R2, R4)
    push_cmd(3'd1, 12'h010, 16'h0000, "R2 identifier command");
    push_rsp(1'b0, 16'hA5C3, "R4 identifier data");
    send(4'd1, 12'h010, 16'h0000, 2'd0, 8'd0); drain();

    push_cmd(3'd2, 12'h011, 16'h1111, "R2 status command");
    push_rsp(1'b0, 16'h00E0, "R4 status data");
    send(4'd2, 12'h011, 16'h1111, 2'd0, 8'd0); drain();

    push_cmd(3'd0, 12'h000, 16'h2222, "R2 reset command");
    push_rsp(1'b0, 16'h0000, "R4 reset response");
    send(4'd0, 12'h000, 16'h2222, 2'd0, 8'd0); drain();

    push_cmd(3'd3, 12'h040, 16'h0000, "R2 erase command");
    push_rsp(1'b0, 16'h0000, "R4 erase pass");
    send(4'd3, 12'h040, 16'h0000, 2'd0, 8'd0); drain();

    fail_idx = ep_count;
    push_cmd(3'd3, 12'h041, 16'h0000, "R2 erase command");
    push_rsp(1'b1, 16'h0000, "R4 erase fail status");
    send(4'd3, 12'h041, 16'h0000, 2'd0, 8'd0); drain();
    fail_idx = -1;

    push_cmd(3'd4, 12'h042, 16'h3C3C, "R2 program command");
    push_rsp(1'b0, 16'h0000, "R4 program pass");
    send(4'd4, 12'h042, 16'h3C3C, 2'd0, 8'd0); drain();

    page_word = 16'hBEEF;
    push_cmd(3'd5, 12'h042, 16'h0000, "R2 read command");
    push_rsp(1'b0, 16'hBEEF, "R4 read data");
    send(4'd5, 12'h042, 16'h0000, 2'd0, 8'd0); drain();
    chk(rsp_cyc - cmd_cyc == busy_cycles + 2, "R3 response latency",
        32'(rsp_cyc - cmd_cyc), 32'(busy_cycles + 2));

    // threshold write then immediate read-back (R5, R6)
    push_rsp(1'b0, 16'h0000, "R5 threshold write");
    push_rsp(1'b0, 16'h005A, "R6 read-back after write");
    send(4'd6, 12'h000, 16'hFF5A, 2'd1, 8'd0);
    send(4'd7, 12'h000, 16'h0000, 2'd1, 8'd0);
    drain();
    chk(fl_ref_lvl == 24'hC05A40, "R5 threshold bus", 32'(fl_ref_lvl), 32'hC05A40);

    push_rsp(1'b0, 16'h0040, "R6 read slot 0");
    send(4'd7, 12'h000, 16'h0000, 2'd0, 8'd0); drain();

    // bad slot (R7)
    push_rsp(1'b1, 16'h0000, "R7 write to slot 3");
    push_rsp(1'b1, 16'h0000, "R7 read of slot 3");
    send(4'd6, 12'h000, 16'h0011, 2'd3, 8'd0);
    send(4'd7, 12'h000, 16'h0000, 2'd3, 8'd0);
    drain();
    chk(fl_ref_lvl == 24'hC05A40, "R7 thresholds unchanged", 32'(fl_ref_lvl), 32'hC05A40);

    // undefined codes (R8)
    push_rsp(1'b1, 16'h0000, "R8 code 12");
    send(4'd12, 12'h000, 16'h0000, 2'd0, 8'd0);
    push_rsp(1'b1, 16'h0000, "R8 code 9");
    send(4'd9, 12'h000, 16'h0000, 2'd0, 8'd0);
    drain();

    // wear run, three passes (R9, R10): errors 2, 5, 1
    rd_words.push_back(16'hF0F0 ^ 16'h0003);
    rd_words.push_back(16'hF0F0 ^ 16'h001F);
    rd_words.push_back(16'hF0F0 ^ 16'h0100);
    for (int i = 0; i < 3; i++) begin
      push_cmd(3'd3, 12'h123, 16'hF0F0, "R9 wear erase");
      push_cmd(3'd4, 12'h123, 16'hF0F0, "R9 wear program");
      push_cmd(3'd5, 12'h123, 16'hF0F0, "R9 wear read");
    end
    push_rsp(1'b0, 16'd5, "R10 maximum error count");
    send(4'd8, 12'h123, 16'hF0F0, 2'd0, 8'd3); drain();
    chk(cmd_q.size() == 0, "R9 all wear commands seen", 32'(cmd_q.size()), 0);

    // zero passes (R12)
    push_rsp(1'b0, 16'h0000, "R12 zero pass run");
    send(4'd8, 12'h124, 16'hAAAA, 2'd0, 8'd0); drain();

    // abort on second program (R11): first pass has 3 errors
    rd_words.push_back(16'h5555 ^ 16'h0007);
    fail_idx = ep_count + 3;
    push_cmd(3'd3, 12'h200, 16'h5555, "R11 erase pass 1");
    push_cmd(3'd4, 12'h200, 16'h5555, "R11 program pass 1");
    push_cmd(3'd5, 12'h200, 16'h5555, "R11 read pass 1");
    push_cmd(3'd3, 12'h200, 16'h5555, "R11 erase pass 2");
    push_cmd(3'd4, 12'h200, 16'h5555, "R11 program pass 2");
    push_rsp(1'b1, 16'd3, "R11 aborted run");
    send(4'd8, 12'h200, 16'h5555, 2'd0, 8'd4); drain();
    repeat (8) @(negedge clk);
    fail_idx = -1;
    chk(cmd_q.size() == 0, "R11 no command after abort", 32'(cmd_q.size()), 0);

    // queued request behind a running one (R13)
    overlap_seen = 1'b0;
    push_cmd(3'd2, 12'h300, 16'h0000, "R13 first command");
    push_rsp(1'b0, 16'h00E0, "R13 first response");
    push_cmd(3'd1, 12'h301, 16'h0000, "R13 second command");
    push_rsp(1'b0, 16'hA5C3, "R13 second response");
    send(4'd2, 12'h300, 16'h0000, 2'd0, 8'd0);
    send(4'd1, 12'h301, 16'h0000, 2'd0, 8'd0);
    drain();
    chk(overlap_seen, "R13 accept in response cycle", 32'(overlap_seen), 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && cmd_q.size() == 0, "R2 scoreboard empty",
        32'(exp_q.size() + cmd_q.size()), 0);
    finish_run();
  end

endmodule